// File: doc/BRIEF.md
# Stride-Context Trace Value Compressor

This block is the first, prediction-based filtering stage of a two-stage trace compressor. It takes a stream of 64-bit trace values, for example program-counter samples, and replaces each value that it can predict with a short code naming the prediction that matched. A value that no prediction covers is sent as an escape code followed by the raw value. A general-purpose compressor further down the chain then works on this filtered stream.

Accepted values first enter a small FIFO, so that short bursts from the producer are absorbed. The predictor keeps the last value and the last stride (the difference between two values in a row). A hash of the last stride selects one row of a stride table. Each row holds the five most recent strides that followed that context. Each valid entry gives a candidate, equal to the last value plus that stride. A comparator finds the lowest-numbered candidate that equals the actual value. Every output word is 64 bits wide and leaves as two 32-bit beats.

Both sides use valid/ready handshakes. A beat moves on a rising edge at which both valid and ready are high. While `out_ready` is low, `out_valid` and `out_data` hold their values. Once the FIFO is full, `in_ready` falls and the producer must wait, so no value is ever dropped.

Top module: `dfcm_trace_compressor`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Reset clears every table entry, the last value and the last stride. So the first value after reset is always sent as an escape.
- R3: A value equal to the last value plus the valid stride in position k (0 to 4, position 0 the most recent) of the selected row is sent as code k. When several positions match, the lowest k wins.
- R4: A value that matches no valid candidate is sent as code 7 (escape). The escape word is followed by a word holding the raw 64-bit value.
- R5: A code word is the 64-bit value {61'b0, code}. Every 64-bit word leaves as two beats, with bits 63:32 first and bits 31:0 second.
- R6: After every value, the new stride (value minus last value) is written into position 0 of the row selected by the previous stride. Positions 0 to 3 shift to 1 to 4 and the entry in position 4 is dropped, so a stride that is six insertions old no longer predicts.
- R7: The row index is the XOR of all sixteen 4-bit groups of the last stride. Two strides with equal XOR share one row.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged on the next cycle.
- R9: `in_ready` is low exactly when the FIFO (default depth 8) is full. With the output stalled, the block accepts depth+1 values (one is held at the output) and then deasserts `in_ready`.
- R10: The output stream holds one code word for every accepted value, in input order, with nothing missing and nothing extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a trace value |
| in_ready | output | 1 | Block can accept a value |
| in_data | input | 64 | Trace value |
| out_valid | output | 1 | An output beat is present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 32 | Output beat: half of a code word or of a raw word |

## Verification
The assertions assume that the consumer follows the handshake, with `out_ready` free to change at any time. They also assume that the producer keeps `in_data` fixed until the value is accepted. The bench drives both sides from a single process at the falling edge. It changes `in_data` only after a handshake, and it toggles `out_ready` at random to create stalls. Sequences with repeated strides, with hash collisions and with six-deep evictions, mixed with fully random values, drive the stride table into hits, priority ties and misses.

// File: rtl/dfcm_pkg.sv
package dfcm_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] ESC_CODE = 3'd7;
endpackage

// File: rtl/trace_fifo.sv
module trace_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign head_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= din_i;
        wr_q        <= bump(wr_q);
      end
      if (pop_i) rd_q <= bump(rd_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R9
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  // R9
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |=> count_q == $past(count_q) + CW'(1));
endmodule

// File: rtl/stride_predictor.sv
module stride_predictor
  import dfcm_pkg::*;
#(
  parameter int VAL_W = 64,
  parameter int ROWS  = 16,
  parameter int NCAND = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int IDX_W  = $clog2(ROWS);
  localparam int GROUPS = VAL_W / IDX_W;

  logic [VAL_W-1:0] tbl_q [ROWS][NCAND];
  logic [NCAND-1:0] vld_q [ROWS];
  logic [VAL_W-1:0] last_q, stride_q, new_stride;
  logic [IDX_W-1:0] row;
  logic [NCAND-1:0] match;

  always_comb begin
    row = '0;
    for (int g = 0; g < GROUPS; g++) row ^= stride_q[g*IDX_W +: IDX_W];
  end

  assign new_stride = value_i - last_q;

  for (genvar k = 0; k < NCAND; k++) begin : g_cmp
    assign match[k] = vld_q[row][k] && (value_i == last_q + tbl_q[row][k]);
  end

  always_comb begin
    code_o = ESC_CODE;
    for (int k = NCAND - 1; k >= 0; k--)
      if (match[k]) code_o = CODE_W'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) begin
        vld_q[r] <= '0;
        for (int k = 0; k < NCAND; k++) tbl_q[r][k] <= '0;
      end
      last_q   <= '0;
      stride_q <= '0;
    end else if (step_i) begin
      tbl_q[row][0] <= new_stride;
      for (int k = 1; k < NCAND; k++) tbl_q[row][k] <= tbl_q[row][k-1];
      vld_q[row] <= {vld_q[row][NCAND-2:0], 1'b1};
      last_q     <= value_i;
      stride_q   <= new_stride;
    end
  end

  // R2
  empty_row_esc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && (vld_q[row] == '0) |-> code_o == ESC_CODE);
  // R3
  hit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && code_o != ESC_CODE |-> code_o < CODE_W'(NCAND));
  // R6
  last_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> last_q == $past(value_i));
endmodule

// File: rtl/beat_serializer.sv
module beat_serializer
  import dfcm_pkg::*;
#(
  parameter int VAL_W  = 64,
  parameter int BEAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [VAL_W-1:0]  raw_i,
  output logic              idle_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [BEAT_W-1:0] out_data_o
);
  localparam int BPW   = VAL_W / BEAT_W;
  localparam int BUF_W = 2 * VAL_W;
  localparam int RW    = $clog2(2 * BPW + 1);

  logic [BUF_W-1:0] buf_q;
  logic [RW-1:0]    rem_q;
  logic             fire;

  assign out_valid_o = (rem_q != '0);
  assign out_data_o  = buf_q[BUF_W-1 -: BEAT_W];
  assign fire        = out_valid_o && out_ready_i;
  assign idle_o      = (rem_q == '0) || (rem_q == RW'(1) && out_ready_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      buf_q <= {(VAL_W-CODE_W)'(0), code_i, raw_i};
      rem_q <= (code_i == ESC_CODE) ? RW'(2 * BPW) : RW'(BPW);
    end else if (fire) begin
      buf_q <= {buf_q[BUF_W-BEAT_W-1:0], BEAT_W'(0)};
      rem_q <= rem_q - RW'(1);
    end
  end

  // R5
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> idle_o);
  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/dfcm_trace_compressor.sv
module dfcm_trace_compressor
  import dfcm_pkg::*;
#(
  parameter int VAL_W  = 64,
  parameter int BEAT_W = 32,
  parameter int DEPTH  = 8,
  parameter int ROWS   = 16,
  parameter int NCAND  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VAL_W-1:0]  in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data
);
  logic             full, empty, idle, push, pop;
  logic [VAL_W-1:0] head;
  logic [CODE_W-1:0] code;

  assign in_ready = !full;
  assign push     = in_valid && !full;
  assign pop      = !empty && idle;

  trace_fifo #(.W(VAL_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .din_i(in_data),
    .pop_i(pop), .head_o(head), .full_o(full), .empty_o(empty));

  stride_predictor #(.VAL_W(VAL_W), .ROWS(ROWS), .NCAND(NCAND)) u_pred (
    .clk(clk), .rst_n(rst_n), .step_i(pop), .value_i(head), .code_o(code));

  beat_serializer #(.VAL_W(VAL_W), .BEAT_W(BEAT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load_i(pop), .code_i(code), .raw_i(head),
    .idle_o(idle), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data));

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && in_ready);
endmodule

// File: tb/tb_dfcm_trace_compressor.sv
`timescale 1ns/1ps
module tb_dfcm_trace_compressor;
  logic        clk = 0, rst_n = 0;
  logic        in_valid = 0, out_ready = 0;
  logic [63:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  dfcm_trace_compressor dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  int checks = 0, fails = 0;
  bit done = 0;

  logic [63:0] m_last, m_stride;
  logic [63:0] m_tbl [16][5];
  logic [4:0]  m_vld [16];
  bit          m_first;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  string       phase_tag = "";

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] m_hash(logic [63:0] s);
    logic [3:0] h = '0;
    for (int g = 0; g < 16; g++) h ^= s[g*4 +: 4];
    return h;
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 16; r++) begin
      m_vld[r] = '0;
      for (int k = 0; k < 5; k++) m_tbl[r][k] = '0;
    end
    m_last = '0; m_stride = '0; m_first = 1;
  endtask

  task automatic model(logic [63:0] v);
    logic [3:0] r = m_hash(m_stride);
    logic [2:0] code = 3'd7;
    logic [63:0] ns = v - m_last;
    string t;
    for (int k = 4; k >= 0; k--)
      if (m_vld[r][k] && v == m_last + m_tbl[r][k]) code = 3'(k);
    for (int k = 4; k >= 1; k--) m_tbl[r][k] = m_tbl[r][k-1];
    m_tbl[r][0] = ns;
    m_vld[r] = {m_vld[r][3:0], 1'b1};
    m_last = v; m_stride = ns;
    t = m_first ? "R2" : (phase_tag != "" ? phase_tag : (code == 3'd7 ? "R4" : "R3"));
    m_first = 0;
    exp_q.push_back(32'h0); tag_q.push_back("R5");
    exp_q.push_back({29'h0, code}); tag_q.push_back(t);
    if (code == 3'd7) begin
      exp_q.push_back(v[63:32]); tag_q.push_back("R4");
      exp_q.push_back(v[31:0]);  tag_q.push_back("R4");
    end
  endtask

  logic [63:0] cur;
  int          accepted;

  task automatic step(bit iv, bit ordy);
    @(negedge clk);
    in_valid = iv; in_data = cur; out_ready = ordy;
    #1;
    if (in_valid && in_ready) begin
      model(cur);
      accepted++;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R10", {32'h0, out_data}, 64'hdead);
      else chk(tag_q.pop_front(), {32'h0, out_data}, {32'h0, exp_q.pop_front()});
    end
  endtask

  task automatic send(logic [63:0] v);
    cur = v;
    accepted = 0;
    while (accepted == 0) step(1, 1);
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 2000) begin
      step(0, 1); n++;
    end
    repeat (3) step(0, 1);
    chk("R10", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk("R1", {62'h0, out_valid, in_ready}, 64'b01);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    chk("R1", {62'h0, out_valid, in_ready}, 64'b01);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    accepted = 0;
    do_reset();

    // R2 / R3: first escape, then a steady stride loop with ties
    send(64'h0000_1000_0000_1000);
    for (int i = 1; i < 24; i++) send(m_last + 64'd4);
    drain();

    // R7: strides 0x1 and 0x10 share a row
    do_reset();
    phase_tag = "R7";
    send(64'h0); send(64'h1); send(64'h9); send(64'h19); send(64'h21);
    phase_tag = "";
    drain();

    // R6: six strides after context 3, then the oldest is gone
    do_reset();
    phase_tag = "R6";
    send(64'h5000);
    for (int i = 1; i <= 6; i++) begin
      send(m_last + 64'h3);
      send(m_last + 64'(64'h40 * i));
    end
    send(m_last + 64'h3); send(m_last + 64'h40);
    send(m_last + 64'h3); send(m_last + 64'h180);
    phase_tag = "";
    drain();

    // R8 / R9: stall the output and fill the FIFO
    accepted = 0;
    cur = 64'hABCD_0000_0000_0000;
    for (int i = 0; i < 20; i++) begin
      step(1, 0);
      if (in_valid && in_ready) cur = cur + 64'h10;
    end
    chk("R9", 64'(accepted), 64'd9);
    chk("R9", {63'h0, in_ready}, 64'd0);
    begin
      logic [31:0] held = out_data;
      for (int i = 0; i < 4; i++) begin
        step(0, 0);
        chk("R8", {31'h0, out_valid, out_data}, {31'h0, 1'b1, held});
      end
    end
    drain();

    // Random mix
    cur = 64'h7000;
    for (int i = 0; i < 4000; i++) begin
      int sel = int'($urandom % 10);
      bit iv = ($urandom % 10) < 7;
      bit ordy = ($urandom % 10) < 6;
      accepted = 0;
      step(iv, ordy);
      if (accepted != 0) begin
        if (sel < 6) cur = m_last + 64'(32'd4 << ($urandom % 3));
        else if (sel < 8) cur = m_last - 64'd12;
        else cur = {$urandom, $urandom};
      end
    end
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule